// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers interrupt requests from up to 32 peripheral sources and turns them into two active-low request lines for a processor: a normal interrupt line and a fast interrupt line. Source 0 is the fast source and drives only the fast line. Sources 1 to 31 compete for the normal line. Each source has a programmable 3-bit priority, a sensitivity bit that selects level or rising-edge behaviour, and a 32-bit handler address.

Software services a normal interrupt by reading the IRQ vector register. That read returns the handler address of the winning source, acknowledges the source, and pushes the winner's priority onto a level stack. While a handler runs, only a source with a strictly higher priority can pull the normal line low again, so interrupts nest by priority. Software writes the end-of-interrupt register when a handler finishes, and that write pops the stack. When no source qualifies, the vector read returns a programmable spurious address and the stack does not change.

The register interface is a simple single-cycle bus. Reads return data combinationally in the cycle where the bus is selected. Writes and read side effects take effect at that cycle's rising clock edge.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset both request outputs are high, the enable mask (0x110) reads 0, every mode, vector and spurious register reads 0, and the level stack is empty.
- R2: The mode register of source n sits at byte offset 4·n. Bits [2:0] hold the priority and bit 4 selects rising-edge sensitivity (1) or level sensitivity (0). The vector register of source n sits at 0x080 + 4·n. Both read back what was written, with the unused mode bits reading 0.
- R3: A write to 0x120 sets every mask bit whose data bit is 1, and a write to 0x124 clears every mask bit whose data bit is 1. All other mask bits are unchanged. The mask reads at 0x110. A masked source cannot pull either request line low.
- R4: The fast line is low exactly when source 0 is enabled and pending. Reading 0x104 returns the vector of source 0 and acknowledges it. Sources 1 to 31 never affect the fast line, and source 0 never affects the normal line.
- R5: The normal line is low when an enabled, pending source among 1 to 31 exists and either the stack is empty or the priority of the best such source is strictly greater than the priority on top of the stack.
- R6: The best source is the one with the highest priority (7 is highest). Among equal priorities, the lowest index wins. Reading 0x100 while the normal line is low returns that source's vector.
- R7: A read of 0x100 while the normal line is low pushes the winner's priority onto an 8-entry stack and acknowledges the winner.
- R8: A write to 0x130 pops one stack entry. When the stack is empty the write has no effect.
- R9: In edge mode, a rising input edge sets a pending latch that holds after the input falls, until the source is acknowledged. In level mode, pending follows the input directly.
- R10: A read of 0x100 while the normal line is high returns the value of the spurious register at 0x134 and leaves the stack unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Interrupt inputs, one per source |
| bus_sel_i | input | 1 | Register access in this cycle |
| bus_wr_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | 9 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the selected register |
| irq_n_o | output | 1 | Normal interrupt request, active low |
| fiq_n_o | output | 1 | Fast interrupt request, active low |

## Verification
On every cycle, the assertions check how the stack depth moves: it rises by one on an acknowledged vector read, falls by one on an end-of-interrupt write to a non-empty stack, and stays put on a spurious read or on an end-of-interrupt write to an empty stack. They also check that the spurious value is returned whenever the normal line is high, that the depth stays bounded, and that the fast line rises once source 0 is masked. Only the bench's scenarios can show the rest: which source wins arbitration over hundreds of request patterns and two priority maps, that nesting blocks equal and lower priorities, and that edge latches hold and clear.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    localparam int EDGE_BIT = 4;

    localparam logic [8:0] OFF_IRQ_VEC  = 9'h100;
    localparam logic [8:0] OFF_FIQ_VEC  = 9'h104;
    localparam logic [8:0] OFF_MASK_RD  = 9'h110;
    localparam logic [8:0] OFF_MASK_SET = 9'h120;
    localparam logic [8:0] OFF_MASK_CLR = 9'h124;
    localparam logic [8:0] OFF_EOI      = 9'h130;
    localparam logic [8:0] OFF_SPUR     = 9'h134;

    typedef enum logic [3:0] {
        K_NONE, K_MODE, K_VEC, K_IRQV, K_FIQV,
        K_MASK, K_MSET, K_MCLR, K_EOI, K_SPUR
    } reg_kind_e;
endpackage

// File: rtl/irqv_pending.sv
module irqv_pending #(
    parameter int NSRC = 32
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NSRC-1:0] src_i,
    input  logic [NSRC-1:0] edge_md_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] pend_o
);
    typedef struct packed {
        logic [NSRC-1:0] prev;
        logic [NSRC-1:0] latch;
    } pend_st_t;

    pend_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.prev = src_i;
        for (int i = 0; i < NSRC; i++) begin
            // a fresh edge outranks an acknowledge in the same cycle
            s_d.latch[i] = edge_md_i[i] &
                           ((s_q.latch[i] & ~clr_i[i]) | (src_i[i] & ~s_q.prev[i]));
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_sel
            assign pend_o[g] = edge_md_i[g] ? s_q.latch[g] : src_i[g];
        end
    endgenerate
endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter #(
    parameter int NSRC   = 32,
    parameter int PRIO_W = 3,
    localparam int IDX_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]             req_i,
    input  logic [NSRC-1:0][PRIO_W-1:0] prio_i,
    output logic                        valid_o,
    output logic [IDX_W-1:0]            idx_o,
    output logic [PRIO_W-1:0]           prio_o
);
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        prio_o  = '0;
        // walk downward so an equal priority hands the grant to the lower index
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req_i[i] && (!valid_o || prio_i[i] >= prio_o)) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
                prio_o  = prio_i[i];
            end
        end
    end
endmodule

// File: rtl/irqv_level_stack.sv
module irqv_level_stack #(
    parameter int PRIO_W = 3,
    localparam int DEPTH = 1 << PRIO_W,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [PRIO_W-1:0] level_i,
    output logic              busy_o,
    output logic [PRIO_W-1:0] top_o,
    output logic [CNT_W-1:0]  depth_o
);
    typedef struct packed {
        logic [DEPTH-1:0][PRIO_W-1:0] ent;
        logic [CNT_W-1:0]             cnt;
    } stk_st_t;

    stk_st_t s_d, s_q;
    logic [PRIO_W-1:0] wr_ptr, top_ptr;

    assign wr_ptr  = s_q.cnt[PRIO_W-1:0];
    assign top_ptr = wr_ptr - 1'b1;

    always_comb begin
        s_d = s_q;
        if (push_i && s_q.cnt < CNT_W'(DEPTH)) begin
            s_d.ent[wr_ptr] = level_i;
            s_d.cnt         = s_q.cnt + 1'b1;
        end else if (pop_i && s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign busy_o  = (s_q.cnt != '0);
    assign top_o   = s_q.ent[top_ptr];
    assign depth_o = s_q.cnt;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqv_pkg::*;
#(
    parameter int NSRC   = 32,
    parameter int PRIO_W = 3,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 9,
    localparam int IDX_W = $clog2(NSRC),
    localparam int CNT_W = $clog2((1 << PRIO_W) + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NSRC-1:0]   src_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_n_o,
    output logic              fiq_n_o
);
    typedef struct packed {
        logic [NSRC-1:0][PRIO_W-1:0] prio;
        logic [NSRC-1:0]             edge_md;
        logic [NSRC-1:0][DATA_W-1:0] vec;
        logic [NSRC-1:0]             en;
        logic [DATA_W-1:0]           spur;
    } regs_t;

    regs_t r_d, r_q;

    reg_kind_e         kind;
    logic [IDX_W-1:0]  idx;
    logic              rd_irqv, rd_fiqv, wr_eoi, irq_go, fiq_go;
    logic [NSRC-1:0]   pend, irq_req, clr;
    logic              win_vld, nested;
    logic [IDX_W-1:0]  win_idx;
    logic [PRIO_W-1:0] win_prio, cur_lvl;
    logic [CNT_W-1:0]  stk_depth;

    // address decode
    always_comb begin
        kind = K_NONE;
        idx  = bus_addr_i[IDX_W+1:2];
        if (bus_addr_i[1:0] == 2'b00) begin
            if (bus_addr_i[8:7] == 2'b00)      kind = K_MODE;
            else if (bus_addr_i[8:7] == 2'b01) kind = K_VEC;
            else begin
                case (bus_addr_i)
                    OFF_IRQ_VEC:  kind = K_IRQV;
                    OFF_FIQ_VEC:  kind = K_FIQV;
                    OFF_MASK_RD:  kind = K_MASK;
                    OFF_MASK_SET: kind = K_MSET;
                    OFF_MASK_CLR: kind = K_MCLR;
                    OFF_EOI:      kind = K_EOI;
                    OFF_SPUR:     kind = K_SPUR;
                    default:      kind = K_NONE;
                endcase
            end
        end
    end

    irqv_pending #(.NSRC(NSRC)) u_pend (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .src_i     (src_i),
        .edge_md_i (r_q.edge_md),
        .clr_i     (clr),
        .pend_o    (pend)
    );

    assign irq_req = pend & r_q.en & {{(NSRC-1){1'b1}}, 1'b0};

    irqv_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
        .req_i   (irq_req),
        .prio_i  (r_q.prio),
        .valid_o (win_vld),
        .idx_o   (win_idx),
        .prio_o  (win_prio)
    );

    irqv_level_stack #(.PRIO_W(PRIO_W)) u_stk (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .push_i  (rd_irqv && irq_go),
        .pop_i   (wr_eoi),
        .level_i (win_prio),
        .busy_o  (nested),
        .top_o   (cur_lvl),
        .depth_o (stk_depth)
    );

    assign irq_go  = win_vld && (!nested || win_prio > cur_lvl);
    assign fiq_go  = r_q.en[0] && pend[0];
    assign rd_irqv = bus_sel_i && !bus_wr_i && kind == K_IRQV;
    assign rd_fiqv = bus_sel_i && !bus_wr_i && kind == K_FIQV;
    assign wr_eoi  = bus_sel_i &&  bus_wr_i && kind == K_EOI;
    assign irq_n_o = !irq_go;
    assign fiq_n_o = !fiq_go;

    // acknowledge clears the edge latch of the served source
    always_comb begin
        clr = '0;
        if (rd_irqv && irq_go) clr[win_idx] = 1'b1;
        if (rd_fiqv)           clr[0]       = 1'b1;
    end

    // read data
    always_comb begin
        bus_rdata_o = '0;
        case (kind)
            K_MODE: begin
                bus_rdata_o[PRIO_W-1:0] = r_q.prio[idx];
                bus_rdata_o[EDGE_BIT]   = r_q.edge_md[idx];
            end
            K_VEC:  bus_rdata_o = r_q.vec[idx];
            K_IRQV: bus_rdata_o = irq_go ? r_q.vec[win_idx] : r_q.spur;
            K_FIQV: bus_rdata_o = r_q.vec[0];
            K_MASK: bus_rdata_o[NSRC-1:0] = r_q.en;
            K_SPUR: bus_rdata_o = r_q.spur;
            default: bus_rdata_o = '0;
        endcase
    end

    // register writes
    always_comb begin
        r_d = r_q;
        if (bus_sel_i && bus_wr_i) begin
            case (kind)
                K_MODE: begin
                    r_d.prio[idx]    = bus_wdata_i[PRIO_W-1:0];
                    r_d.edge_md[idx] = bus_wdata_i[EDGE_BIT];
                end
                K_VEC:  r_d.vec[idx] = bus_wdata_i;
                K_MSET: r_d.en = r_q.en |  bus_wdata_i[NSRC-1:0];
                K_MCLR: r_d.en = r_q.en & ~bus_wdata_i[NSRC-1:0];
                K_SPUR: r_d.spur = bus_wdata_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end
endmodule

// File: rtl/irqv_checks.sv
module irqv_checks
    import irqv_pkg::*;
#(
    parameter int PRIO_W = 3,
    localparam int DEPTH = 1 << PRIO_W,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             sel_i,
    input logic             wr_i,
    input logic [8:0]       addr_i,
    input logic [31:0]      wdata_i,
    input logic [31:0]      rdata_i,
    input logic             irq_n_i,
    input logic             fiq_n_i,
    input logic [CNT_W-1:0] depth_i,
    input logic [31:0]      spur_i
);
    logic rd_vec, eoi_wr;
    assign rd_vec = sel_i && !wr_i && addr_i == OFF_IRQ_VEC;
    assign eoi_wr = sel_i &&  wr_i && addr_i == OFF_EOI;

    p_depth_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        depth_i <= CNT_W'(DEPTH));

    p_ack_push_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_vec && !irq_n_i) |=> depth_i == $past(depth_i) + 1'b1);

    p_spur_data_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_vec && irq_n_i) |-> rdata_i == spur_i);

    p_spur_keep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_vec && irq_n_i) |=> depth_i == $past(depth_i));

    p_eoi_pop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eoi_wr && depth_i != '0) |=> depth_i == $past(depth_i) - 1'b1);

    p_eoi_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eoi_wr && depth_i == '0) |=> depth_i == '0);

    p_fiq_masked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i && wr_i && addr_i == OFF_MASK_CLR && wdata_i[0]) |=> fiq_n_i);
endmodule

bind irq_vector_ctrl irqv_checks #(.PRIO_W(PRIO_W)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (bus_sel_i),
    .wr_i    (bus_wr_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .rdata_i (bus_rdata_o),
    .irq_n_i (irq_n_o),
    .fiq_n_i (fiq_n_o),
    .depth_i (stk_depth),
    .spur_i  (r_q.spur)
);

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [8:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_n, fiq_n;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    logic [31:0] lfsr = 32'h1357_9BDF;
    logic [2:0]  prio_tab [32];

    always #10 clk = ~clk;

    irq_vector_ctrl i_irq_vector_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .src_i(src),
        .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_n_o(irq_n), .fiq_n_o(fiq_n)
    );

    function automatic logic [31:0] vec_of(int n);
        return 32'h0100_0000 + 32'(n) * 32'h10;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // tasks start and end at a falling edge
    task automatic bus_wr(logic [8:0] a, logic [31:0] d);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_rd(logic [8:0] a, output logic [31:0] d);
        sel = 1'b1; wr = 1'b0; addr = a;
        #5 d = rdata;
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // expected winner from the arbitration rule: highest priority, lowest index on ties
    function automatic int best_src(logic [31:0] req);
        int w = -1;
        for (int n = 1; n < 32; n++)
            if (req[n] && (w < 0 || prio_tab[n] > prio_tab[w])) w = n;
        return w;
    endfunction

    task automatic set_prio(int n, logic [2:0] p, bit edge_md);
        prio_tab[n] = p;
        bus_wr(9'(n * 4), {27'd0, edge_md, 1'b0, p});
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();

        // R1 reset state
        check("R1 irq_n", 32'(irq_n), 32'd1);
        check("R1 fiq_n", 32'(fiq_n), 32'd1);
        bus_rd(9'h110, d); check("R1 mask", d, 32'd0);
        bus_rd(9'h100, d); check("R1 spur", d, 32'd0);
        bus_rd(9'h000, d); check("R1 mode0", d, 32'd0);

        // R2 register programming and readback
        for (int n = 0; n < 32; n++) begin
            set_prio(n, 3'((n * 3 + 1) % 8), 1'b0);
            bus_wr(9'h080 + 9'(n * 4), vec_of(n));
        end
        for (int n = 0; n < 32; n++) begin
            bus_rd(9'(n * 4), d);
            check("R2 mode", d, {29'd0, prio_tab[n]});
            bus_rd(9'h080 + 9'(n * 4), d);
            check("R2 vector", d, vec_of(n));
        end
        bus_wr(9'h004, 32'hFFFF_FFF1);
        bus_rd(9'h004, d); check("R2 mode unused bits", d, 32'h0000_0011);
        set_prio(1, 3'd4, 1'b0);

        // R3 mask set/clear
        bus_wr(9'h120, 32'h0000_00F0);
        bus_wr(9'h120, 32'h0000_0F00);
        bus_rd(9'h110, d); check("R3 set", d, 32'h0000_0FF0);
        bus_wr(9'h124, 32'h0000_0330);
        bus_rd(9'h110, d); check("R3 clear", d, 32'h0000_0CC0);
        src = 32'h0000_0020; tick();
        check("R3 masked source", 32'(irq_n), 32'd1);
        src = '0;
        bus_wr(9'h120, 32'hFFFF_FFFF);
        bus_rd(9'h110, d); check("R3 all", d, 32'hFFFF_FFFF);

        // R5 R6 R7 arbitration sweep over two priority maps
        for (int pass = 0; pass < 2; pass++) begin
            if (pass == 1)
                for (int n = 1; n < 32; n++) set_prio(n, 3'(7 - (n % 8)), 1'b0);
            for (int t = 0; t < 160; t++) begin
                lfsr = {lfsr[30:0], 1'b0} ^ (lfsr[31] ? 32'h04C1_1DB7 : 32'h0);
                src = lfsr & 32'hFFFF_FFFE & (t % 5 == 0 ? 32'h0000_F00E : 32'hFFFF_FFFF);
                if (t % 17 == 0) src = '0;
                tick();
                w = best_src(src);
                check("R5 irq line", 32'(irq_n), (w < 0) ? 32'd1 : 32'd0);
                bus_rd(9'h100, d);
                check("R6 vector", d, (w < 0) ? 32'd0 : vec_of(w));
                bus_wr(9'h130, 32'd0);
            end
        end
        src = '0; tick();

        // R7 R8 nesting
        set_prio(3, 3'd2, 1'b0);
        set_prio(5, 3'd6, 1'b0);
        set_prio(7, 3'd7, 1'b0);
        src = 32'h0000_0028; tick();
        bus_rd(9'h100, d); check("R7 first grant", d, vec_of(5));
        check("R7 equal blocked", 32'(irq_n), 32'd1);
        src[7] = 1'b1; tick();
        check("R7 higher preempts", 32'(irq_n), 32'd0);
        bus_rd(9'h100, d); check("R7 nested grant", d, vec_of(7));
        src[7] = 1'b0; tick();
        check("R7 top level 7", 32'(irq_n), 32'd1);
        bus_wr(9'h130, 32'd0); tick();
        check("R8 pop to 6", 32'(irq_n), 32'd1);
        src[5] = 1'b0;
        bus_wr(9'h130, 32'd0); tick();
        check("R8 pop to empty", 32'(irq_n), 32'd0);
        bus_rd(9'h100, d); check("R8 low prio served", d, vec_of(3));
        bus_wr(9'h130, 32'd0);
        bus_wr(9'h130, 32'd0);
        bus_wr(9'h130, 32'd0); tick();
        check("R8 empty pop harmless", 32'(irq_n), 32'd0);
        bus_rd(9'h100, d); check("R8 grant after empty pops", d, vec_of(3));
        check("R7 same level blocked", 32'(irq_n), 32'd1);
        bus_wr(9'h130, 32'd0);
        src = '0;

        // R9 edge versus level
        set_prio(9, 3'd4, 1'b1);
        set_prio(11, 3'd4, 1'b0);
        src[9] = 1'b1; tick(); src[9] = 1'b0; tick();
        check("R9 edge held", 32'(irq_n), 32'd0);
        bus_rd(9'h100, d); check("R9 edge vector", d, vec_of(9));
        bus_wr(9'h130, 32'd0); tick();
        check("R9 edge cleared by ack", 32'(irq_n), 32'd1);
        bus_rd(9'h024, d); check("R9 edge bit readback", d, 32'h0000_0014);
        src[11] = 1'b1; tick();
        check("R9 level asserted", 32'(irq_n), 32'd0);
        src[11] = 1'b0; tick();
        check("R9 level dropped", 32'(irq_n), 32'd1);

        // R10 spurious
        bus_wr(9'h134, 32'hDEAD_BEEF);
        bus_rd(9'h134, d); check("R10 spur readback", d, 32'hDEAD_BEEF);
        bus_rd(9'h100, d); check("R10 spur vector", d, 32'hDEAD_BEEF);
        src[3] = 1'b1; tick();
        check("R10 stack untouched", 32'(irq_n), 32'd0);
        bus_rd(9'h100, d); check("R10 then grant", d, vec_of(3));
        bus_wr(9'h130, 32'd0);
        src = '0; tick();

        // R4 fast path
        src = 32'h0000_0001; tick();
        check("R4 fiq low", 32'(fiq_n), 32'd0);
        check("R4 src0 not on irq", 32'(irq_n), 32'd1);
        bus_rd(9'h104, d); check("R4 fiq vector", d, vec_of(0));
        src = 32'hFFFF_FFFE; tick();
        check("R4 others not on fiq", 32'(fiq_n), 32'd1);
        src = 32'h0000_0001;
        bus_wr(9'h124, 32'h0000_0001); tick();
        check("R3 fiq masked", 32'(fiq_n), 32'd1);
        bus_wr(9'h120, 32'h0000_0001); tick();
        check("R3 fiq unmasked", 32'(fiq_n), 32'd0);
        src = '0;
        set_prio(0, 3'd0, 1'b1);
        src[0] = 1'b1; tick(); src[0] = 1'b0; tick();
        check("R9 fiq edge held", 32'(fiq_n), 32'd0);
        bus_rd(9'h104, d); tick();
        check("R4 fiq ack clears", 32'(fiq_n), 32'd1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule